// File: doc/BRIEF.md
# Prefix-Extended Logical AND Execute Slice

This block executes one instruction of a small CPU whose eight registers are 24 bits wide: a 16-bit bitwise AND with an unconditional form and two forms gated by the carry flag. Prefix words that arrive before the instruction carry 13 immediate bits each. The block holds up to two of them. When any are pending, the second operand is an immediate built from them and not the destination register.

The block sits between an external register file and an external flag register. It decodes the instruction word and drives the two read addresses. It picks the operand and computes the result in the cycle the instruction is valid. The register and flag write-backs are registered and appear on the next cycle. A delay-slot indicator makes the instruction ignore pending prefixes.

Top module: `andx_exec`

## Requirements
- R1: An instruction is recognised only when bits 15:10 equal 001011 and the variant field in bits 6:3 is 1000 (always), 0000 (runs when C=1) or 0100 (runs when C=0). The destination index is in bits 9:7 and the source index in bits 2:0. Any other valid word writes nothing and leaves pending prefixes unchanged.
- R2: With no prefix pending, an executed instruction writes {8'h00, rd[15:0] & rs[15:0]} to rd.
- R3: With one prefix P pending, the written value is {8'h00, rs[15:0] & {3'b000, P}}.
- R4: With two prefixes pending (older A, newer B), the immediate is {A[2:0], B} and the written value is {8'h00, rs[15:0] & imm}.
- R5: A third prefix drops the oldest, so only the two newest count.
- R6: The C=1 form executes only when C is 1, and the C=0 form only when C is 0. A skipped form asserts neither write enable.
- R7: The flag write word is {N, Z, V, C} in bits 3..0. N is result bit 15, Z is set when the 16-bit result is zero, V is 0, and C is the incoming carry.
- R8: Both write enables assert exactly one cycle after an executed instruction and are low otherwise.
- R9: With the delay-slot indicator high, pending prefixes are ignored and the register form of R2 is used.
- R10: Every recognised instruction clears the pending prefixes, whether it executes, is skipped or sits in a delay slot.
- R11: A prefix that arrives in the same cycle as a recognised instruction is not used by it. It becomes the only pending prefix afterwards.
- R12: Reset clears the write enables and discards pending prefixes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| delay_slot | input | 1 | Instruction sits in a branch delay slot |
| ext_valid | input | 1 | Prefix word is valid this cycle |
| ext_imm | input | 13 | Immediate bits carried by the prefix |
| c_flag_in | input | 1 | Current carry flag |
| rf_ra_addr | output | 3 | Read address for the destination register |
| rf_ra_data | input | 16 | Low half of the destination register |
| rf_rb_addr | output | 3 | Read address for the source register |
| rf_rb_data | input | 16 | Low half of the source register |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 24 | Register write value |
| fl_we | output | 1 | Flag write enable |
| fl_wdata | output | 4 | Flag write value {N, Z, V, C} |

## Verification
Two events can fall in the same cycle: a prefix arriving and an instruction consuming the pending prefixes. A delay-slot instruction can also meet a full prefix store. The bench provokes both directly and randomly: it raises ext_valid with instr_valid, and it raises delay_slot after one, two or three prefixes. The result is judged by the value written in that cycle, which must use only the older prefixes. It is also judged by the value written by the next instruction, which must see exactly the one new prefix.

// File: rtl/andx_pkg.sv
package andx_pkg;
  localparam int REG_FIELD_W = 3;
  localparam logic [5:0] AND_OPCODE = 6'b001011;
  localparam logic [3:0] VAR_ALWAYS = 4'b1000;
  localparam logic [3:0] VAR_CSET   = 4'b0000;
  localparam logic [3:0] VAR_CCLR   = 4'b0100;

  typedef enum logic [1:0] {
    GATE_NONE   = 2'd0,
    GATE_ALWAYS = 2'd1,
    GATE_CSET   = 2'd2,
    GATE_CCLR   = 2'd3
  } gate_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/andx_decode.sv
module andx_decode
  import andx_pkg::*;
(
  input  logic                   instr_valid,
  input  logic [15:0]            instr,
  output logic                   hit,
  output gate_e                  gate,
  output logic [REG_FIELD_W-1:0] rd_idx,
  output logic [REG_FIELD_W-1:0] rs_idx
);
  logic [3:0] variant;

  assign variant = instr[6:3];
  assign rd_idx  = instr[9:7];
  assign rs_idx  = instr[2:0];

  always_comb begin
    gate = GATE_NONE;
    if (instr_valid && instr[15:10] == AND_OPCODE) begin
      case (variant)
        VAR_ALWAYS: gate = GATE_ALWAYS;
        VAR_CSET:   gate = GATE_CSET;
        VAR_CCLR:   gate = GATE_CCLR;
        default:    gate = GATE_NONE;
      endcase
    end
  end

  assign hit = (gate != GATE_NONE);
endmodule

// File: rtl/andx_prefix.sv
module andx_prefix #(
  parameter int EXT_W = 13,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [EXT_W-1:0] push_val,
  input  logic             consume,
  output logic [1:0]       depth,
  output logic [IMM_W-1:0] imm
);
  localparam int HI_W = IMM_W - EXT_W;

  logic [EXT_W-1:0] newest;
  logic [HI_W-1:0]  older_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth    <= 2'd0;
      newest   <= '0;
      older_hi <= '0;
    end else if (consume) begin
      older_hi <= '0;
      if (push) begin
        newest <= push_val;
        depth  <= 2'd1;
      end else begin
        depth  <= 2'd0;
      end
    end else if (push) begin
      older_hi <= newest[HI_W-1:0];
      newest   <= push_val;
      if (depth != 2'd2) depth <= depth + 2'd1;
    end
  end

  always_comb begin
    case (depth)
      2'd1:    imm = {{HI_W{1'b0}}, newest};
      2'd2:    imm = {older_hi, newest};
      default: imm = '0;
    endcase
  end

  // R5
  depth_range_chk: assert property (@(posedge clk) disable iff (rst)
    depth != 2'd3);

  // R10
  consume_clear_chk: assert property (@(posedge clk) disable iff (rst)
    consume && !push |=> depth == 2'd0);

  // R11
  consume_reload_chk: assert property (@(posedge clk) disable iff (rst)
    consume && push |=> depth == 2'd1);

  // R5
  push_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    push && !consume && depth == 2'd2 |=> depth == 2'd2);
endmodule

// File: rtl/andx_alu.sv
module andx_alu #(
  parameter int OP_W = 16
) (
  input  logic [OP_W-1:0] opnd_a,
  input  logic [OP_W-1:0] opnd_b,
  output logic [OP_W-1:0] result,
  output logic            neg,
  output logic            zero
);
  assign result = opnd_a & opnd_b;
  assign neg    = result[OP_W-1];
  assign zero   = (result == '0);
endmodule

// File: rtl/andx_exec.sv
module andx_exec
  import andx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int OP_W   = 16,
  parameter int EXT_W  = 13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   instr_valid,
  input  logic [15:0]            instr,
  input  logic                   delay_slot,
  input  logic                   ext_valid,
  input  logic [EXT_W-1:0]       ext_imm,
  input  logic                   c_flag_in,
  output logic [REG_FIELD_W-1:0] rf_ra_addr,
  input  logic [OP_W-1:0]        rf_ra_data,
  output logic [REG_FIELD_W-1:0] rf_rb_addr,
  input  logic [OP_W-1:0]        rf_rb_data,
  output logic                   rf_we,
  output logic [REG_FIELD_W-1:0] rf_waddr,
  output logic [DATA_W-1:0]      rf_wdata,
  output logic                   fl_we,
  output logic [3:0]             fl_wdata
);
  localparam int PAD_W = DATA_W - OP_W;

  logic                   hit;
  gate_e                  gate;
  logic [REG_FIELD_W-1:0] rd_idx;
  logic [REG_FIELD_W-1:0] rs_idx;
  logic [1:0]             depth;
  logic [OP_W-1:0]        imm;
  logic                   cond_ok;
  logic                   take;
  logic                   use_imm;
  logic [OP_W-1:0]        opnd_a;
  logic [OP_W-1:0]        result;
  logic                   neg;
  logic                   zero;
  flags_t                 fl_next;

  andx_decode u_dec (
    .instr_valid (instr_valid),
    .instr       (instr),
    .hit         (hit),
    .gate        (gate),
    .rd_idx      (rd_idx),
    .rs_idx      (rs_idx)
  );

  andx_prefix #(.EXT_W(EXT_W), .IMM_W(OP_W)) u_pfx (
    .clk      (clk),
    .rst      (rst),
    .push     (ext_valid),
    .push_val (ext_imm),
    .consume  (hit),
    .depth    (depth),
    .imm      (imm)
  );

  always_comb begin
    case (gate)
      GATE_ALWAYS: cond_ok = 1'b1;
      GATE_CSET:   cond_ok = c_flag_in;
      GATE_CCLR:   cond_ok = !c_flag_in;
      default:     cond_ok = 1'b0;
    endcase
  end

  assign take       = hit && cond_ok;
  assign use_imm    = (depth != 2'd0) && !delay_slot;
  assign opnd_a     = use_imm ? imm : rf_ra_data;
  assign rf_ra_addr = rd_idx;
  assign rf_rb_addr = rs_idx;

  andx_alu #(.OP_W(OP_W)) u_alu (
    .opnd_a (opnd_a),
    .opnd_b (rf_rb_data),
    .result (result),
    .neg    (neg),
    .zero   (zero)
  );

  always_comb begin
    fl_next.n = neg;
    fl_next.z = zero;
    fl_next.v = 1'b0;
    fl_next.c = c_flag_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      fl_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      fl_wdata <= '0;
    end else begin
      rf_we <= take;
      fl_we <= take;
      if (take) begin
        rf_waddr <= rd_idx;
        rf_wdata <= {{PAD_W{1'b0}}, result};
        fl_wdata <= fl_next;
      end
    end
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !rf_we && !fl_we);

  // R7
  pair_we_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we == fl_we);

  // R2
  upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_wdata[DATA_W-1:OP_W] == '0);

  // R7
  v_clear_chk: assert property (@(posedge clk) disable iff (rst)
    fl_we |-> !fl_wdata[1]);

  // R7
  zero_match_chk: assert property (@(posedge clk) disable iff (rst)
    fl_we |-> fl_wdata[2] == (rf_wdata[OP_W-1:0] == '0));

  // R7
  c_keep_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> !fl_we || fl_wdata[0] == $past(c_flag_in));
endmodule

// File: tb/sim_andx_exec.sv
module sim_andx_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        delay_slot = 1'b0;
  logic        ext_valid = 1'b0;
  logic [12:0] ext_imm = '0;
  logic        c_flag_in = 1'b0;
  logic [2:0]  rf_ra_addr, rf_rb_addr, rf_waddr;
  logic [15:0] rf_ra_data, rf_rb_data;
  logic        rf_we, fl_we;
  logic [23:0] rf_wdata;
  logic [3:0]  fl_wdata;

  logic [23:0] regs [8];
  int          pcnt = 0;
  logic [12:0] p_new = '0;
  logic [2:0]  p_old = '0;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_ra_data = regs[rf_ra_addr][15:0];
  assign rf_rb_data = regs[rf_rb_addr][15:0];

  andx_exec u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .delay_slot(delay_slot), .ext_valid(ext_valid), .ext_imm(ext_imm),
    .c_flag_in(c_flag_in), .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf_ra_data),
    .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .fl_we(fl_we), .fl_wdata(fl_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] var4, input logic [2:0] rd, input logic [2:0] rs);
    return {6'b001011, rd, var4, rs};
  endfunction

  function automatic logic [15:0] pend_imm();
    if (pcnt == 1) return {3'b000, p_new};
    if (pcnt == 2) return {p_old, p_new};
    return 16'h0;
  endfunction

  task automatic model_push(input logic [12:0] v);
    p_old = p_new[2:0];
    p_new = v;
    if (pcnt < 2) pcnt++;
  endtask

  task automatic prefix(input logic [12:0] v);
    ext_valid = 1'b1;
    ext_imm   = v;
    @(negedge clk);
    ext_valid = 1'b0;
    model_push(v);
    chk("R8 prefix alone", {31'b0, rf_we}, 32'd0);
  endtask

  task automatic exec(input string req, input logic [15:0] w, input logic ds,
                      input logic xv, input logic [12:0] xi);
    logic        hit, go;
    logic [15:0] a, res;
    hit = (w[15:10] == 6'b001011) &&
          (w[6:3] == 4'b1000 || w[6:3] == 4'b0000 || w[6:3] == 4'b0100);
    go  = hit && (w[6:3] == 4'b1000 || (w[6:3] == 4'b0000 && c_flag_in) ||
                  (w[6:3] == 4'b0100 && !c_flag_in));
    a   = (pcnt > 0 && !ds) ? pend_imm() : regs[w[9:7]][15:0];
    res = a & regs[w[2:0]][15:0];
    instr_valid = 1'b1; instr = w; delay_slot = ds; ext_valid = xv; ext_imm = xi;
    @(negedge clk);
    instr_valid = 1'b0; delay_slot = 1'b0; ext_valid = 1'b0;
    chk({req, " we"}, {31'b0, rf_we}, {31'b0, go});
    chk({req, " flag we"}, {31'b0, fl_we}, {31'b0, go});
    if (go) begin
      chk({req, " waddr"}, {29'b0, rf_waddr}, {29'b0, w[9:7]});
      chk({req, " wdata"}, {8'b0, rf_wdata}, {16'b0, res});
      chk({req, " R7 flags"}, {28'b0, fl_wdata}, {28'b0, res[15], res == 16'h0, 1'b0, c_flag_in});
      regs[w[9:7]] = {8'h00, res};
    end
    if (hit) pcnt = 0;
    if (xv) model_push(xi);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) regs[i] = 24'hA50000 | (24'h1111 * i) | 24'h00F0F0;
    // R12: prefix given during reset must be discarded
    ext_valid = 1'b1; ext_imm = 13'h0001;
    repeat (3) @(negedge clk);
    ext_valid = 1'b0;
    chk("R12 rf_we in reset", {31'b0, rf_we}, 32'd0);
    chk("R12 fl_we in reset", {31'b0, fl_we}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    exec("R12 register form after reset", mk(4'b1000, 3'd1, 3'd2), 1'b0, 1'b0, 13'h0);
    // R2 plain form, self AND
    exec("R2", mk(4'b1000, 3'd0, 3'd0), 1'b0, 1'b0, 13'h0);
    // R4 two prefixes -> 0x3fff
    regs[2] = 24'hFFFFFF;
    prefix(13'h0001); prefix(13'h1FFF);
    exec("R4", mk(4'b1000, 3'd1, 3'd2), 1'b0, 1'b0, 13'h0);
    chk("R4 value", {8'b0, regs[1]}, 32'h00003FFF);
    // R3 one prefix, source untouched
    prefix(13'h1234);
    exec("R3", mk(4'b1000, 3'd3, 3'd2), 1'b0, 1'b0, 13'h0);
    chk("R3 rs intact", {8'b0, regs[2]}, 32'h00FFFFFF);
    // R5 third prefix drops oldest
    prefix(13'h0007); prefix(13'h0002); prefix(13'h1555);
    exec("R5", mk(4'b1000, 3'd4, 3'd2), 1'b0, 1'b0, 13'h0);
    chk("R5 value", {8'b0, regs[4]}, 32'h00005555);
    // R9 delay slot ignores prefixes; R10 they are gone afterwards
    prefix(13'h0F0F); prefix(13'h0003);
    exec("R9", mk(4'b1000, 3'd5, 3'd2), 1'b1, 1'b0, 13'h0);
    exec("R10 after delay slot", mk(4'b1000, 3'd6, 3'd2), 1'b0, 1'b0, 13'h0);
    // R6 skipped forms, R10 skip still consumes
    c_flag_in = 1'b0;
    prefix(13'h00FF);
    exec("R6 cset skipped", mk(4'b0000, 3'd7, 3'd2), 1'b0, 1'b0, 13'h0);
    exec("R10 after skip", mk(4'b0100, 3'd7, 3'd2), 1'b0, 1'b0, 13'h0);
    c_flag_in = 1'b1;
    exec("R6 cset runs", mk(4'b0000, 3'd6, 3'd2), 1'b0, 1'b0, 13'h0);
    exec("R6 cclr skipped", mk(4'b0100, 3'd6, 3'd0), 1'b0, 1'b0, 13'h0);
    // R1 bad variant and bad opcode: no write, prefix kept
    prefix(13'h0011);
    exec("R1 bad variant", mk(4'b1001, 3'd1, 3'd2), 1'b0, 1'b0, 13'h0);
    exec("R1 bad opcode", {6'b001010, 3'd1, 4'b1000, 3'd2}, 1'b0, 1'b0, 13'h0);
    exec("R1 prefix kept", mk(4'b1000, 3'd1, 3'd2), 1'b0, 1'b0, 13'h0);
    chk("R1 kept value", {8'b0, regs[1]}, 32'h00000011);
    // R11 prefix alongside instruction
    prefix(13'h1000);
    exec("R11 same cycle", mk(4'b1000, 3'd3, 3'd2), 1'b0, 1'b1, 13'h0ABC);
    exec("R11 next uses new", mk(4'b1000, 3'd4, 3'd2), 1'b0, 1'b0, 13'h0);
    chk("R11 value", {8'b0, regs[4]}, 32'h00000ABC);
    // R7 zero result
    regs[0] = 24'h00F000;
    prefix(13'h0FFF);
    exec("R7 zero", mk(4'b1000, 3'd5, 3'd0), 1'b0, 1'b0, 13'h0);
    // random mix
    for (int k = 0; k < 400; k++) begin
      int np, sel;
      logic [3:0] v;
      logic [15:0] w;
      for (int j = 0; j < 8; j++) if ($urandom % 4 == 0) regs[j] = $urandom;
      np = $urandom % 4;
      for (int j = 0; j < np; j++) prefix(13'($urandom));
      c_flag_in = 1'($urandom);
      sel = $urandom % 5;
      case (sel)
        0: v = 4'b1000;
        1: v = 4'b0000;
        2: v = 4'b0100;
        default: v = 4'($urandom);
      endcase
      w = mk(v, 3'($urandom), 3'($urandom));
      if (sel == 4) w[15:10] = 6'($urandom);
      exec("R2 R3 R4 R6 R9 R11 random", w, ($urandom % 5 == 0),
           ($urandom % 6 == 0), 13'($urandom));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule